// File: doc/BRIEF.md
# Nine-Bit Serial Display Command Transmitter

This block sends command and parameter bytes to a display panel over a serial link that only writes. Each byte is sent as a 9-bit word. The word's first bit is a flag: 0 marks a command and 1 marks a parameter or pixel byte. The eight payload bits follow, most significant bit first. Upstream logic offers one byte at a time on a valid/ready handshake. It tags each byte as command or data and marks the final byte of a burst.

The block has two framings. In native framing every word goes out at once as its own 9-clock frame. In packed framing the block collects up to eight words into a 72-bit group and clocks the group out as nine whole bytes, for serial hosts that can only move 8-bit units. If a burst ends before the group is full, the unused word slots go out as no-op command words (flag 0, payload 0x00).

The serial clock idles low, and the data line changes only while the clock is low (SPI mode 0). Chip-select is active low. It falls when the first word of a burst is accepted, stays low across the whole burst, and rises one serial-clock period after the last bit.

Top module: `spi9_display_tx`

## Requirements
- R1: During and right after reset: `spi_cs_n`=1, `spi_sck`=0, `spi_mosi`=0 and `in_ready`=1.
- R2: Each word is sent flag bit first, then payload bit 7 down to bit 0. The flag is `in_dc`, where 0 means command and 1 means data.
- R3: With `emu_mode`=0 each accepted word starts its own frame of exactly 9 bits on the next clock. A burst of N words gives 9·N rising edges of `spi_sck`.
- R4: With `emu_mode`=1 words are held, not sent, until eight have arrived. The eight then go out as one 72-bit group (nine bytes), word 0 first.
- R5: In packed framing, a word with `in_last`=1 closes the group early. Each empty slot is filled with nine 0 bits, so the group is still exactly 72 bits.
- R6: `spi_sck` is low whenever chip-select is inactive. `spi_mosi` does not change while `spi_sck` is high.
- R7: Each bit lasts 2·HALF_DIV clocks. The first HALF_DIV clocks have `spi_sck` low and the next HALF_DIV have it high, starting on the clock after the word or group that starts the shift is accepted.
- R8: `spi_cs_n` goes low on the clock edge that accepts the first word of a burst. It stays low between words of the burst. It rises 2·HALF_DIV clocks after the final falling edge of `spi_sck` of the last group.
- R9: `in_ready` is 0 while bits are shifting and during the chip-select hold. It is 1 otherwise, including while a packed group is still being collected.
- R10: The framing is taken from `emu_mode` when the first word of a group is accepted. A change of `emu_mode` inside a group has no effect until the group has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emu_mode | input | 1 | 1 selects packed 72-bit groups, 0 selects native 9-bit frames |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| in_dc | input | 1 | 0 = command, 1 = parameter/pixel data |
| in_byte | input | BYTE_W | Payload byte |
| in_last | input | 1 | Final byte of the burst |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip-select |

## Verification
The handshake is accepted on a clock edge. `spi_cs_n` falls on that same edge, and `in_ready` drops on the same edge when the word starts a shift. From then on, bit k of the frame is on `spi_mosi` from edge 2·HALF_DIV·k, and `spi_sck` rises HALF_DIV edges later. The bench keeps a behavioural model that counts edges since the start of the shift. It compares all four outputs to the model at every falling clock edge, half a cycle after the registers have changed. Bits captured at each rising `spi_sck` are then checked against the burst's expected stream, including any padding.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } spi9_state_e;
endpackage

// File: rtl/spi9_sck_gen.sv
module spi9_sck_gen #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic fall
);
   localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   logic [DW-1:0] div;
   logic          hit;

   assign hit  = (div == DW'(HALF_DIV - 1));
   assign fall = run && hit && sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         div <= '0;
         sck <= 1'b0;
      end else if (hit) begin
         div <= '0;
         sck <= ~sck;
      end else begin
         div <= div + 1'b1;
      end
   end

   // R7: the divider never passes its half-period limit
   p_div_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      div <= DW'(HALF_DIV - 1));

   // R7: the clock stays low while the shifter is stopped
   p_stop_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) && !run |-> !sck);
endmodule

// File: rtl/spi9_group_buf.sv
module spi9_group_buf #(
   parameter int WORD_W      = 9,
   parameter int GROUP_WORDS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load,
   input  logic                           first,
   input  logic [$clog2(GROUP_WORDS)-1:0] slot,
   input  logic [WORD_W-1:0]              word,
   input  logic                           shift,
   output logic                           msb
);
   localparam int GROUP_W = WORD_W * GROUP_WORDS;
   localparam int SW      = $clog2(GROUP_WORDS);

   if (GROUP_WORDS < 2) begin : g_bad_words
      $error("GROUP_WORDS must be at least 2");
   end

   logic [GROUP_W-1:0]     sr, sr_n;
   logic [GROUP_WORDS-1:0] slot_we;

   for (genvar g = 0; g < GROUP_WORDS; g++) begin : g_slot
      assign slot_we[g] = load && (slot == SW'(g));
   end

   always_comb begin
      sr_n = sr;
      if (shift) sr_n = {sr[GROUP_W-2:0], 1'b0};
      if (load && first) sr_n = '0;
      for (int g = 0; g < GROUP_WORDS; g++) begin
         if (slot_we[g]) sr_n[GROUP_W-1-g*WORD_W -: WORD_W] = word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= sr_n;
   end

   assign msb = sr[GROUP_W-1];

   // R4: at most one slot is written per accepted word
   p_slot_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_we));

   // R9: no word is accepted while bits are leaving the register
   p_no_load_in_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));
endmodule

// File: rtl/spi9_display_tx.sv
module spi9_display_tx #(
   parameter int BYTE_W      = 8,
   parameter int GROUP_WORDS = 8,
   parameter int HALF_DIV    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              emu_mode,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_dc,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_last,
   output logic              spi_sck,
   output logic              spi_mosi,
   output logic              spi_cs_n
);
   import spi9_pkg::*;

   localparam int WORD_W  = BYTE_W + 1;
   localparam int GROUP_W = WORD_W * GROUP_WORDS;
   localparam int SW      = $clog2(GROUP_WORDS);
   localparam int BCW     = $clog2(GROUP_W + 1);
   localparam int TW      = $clog2(2 * HALF_DIV + 1);

   if (GROUP_W % BYTE_W != 0) begin : g_bad_group
      $error("group length must be a whole number of bytes");
   end

   spi9_state_e   state;
   logic [SW-1:0] slot;
   logic          mode_q, last_q;
   logic [BCW-1:0] bit_cnt, nbits;
   logic [TW-1:0] tail_cnt;
   logic          accept, emu_eff, start, fall, done, msb;

   assign in_ready = (state == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign emu_eff  = (slot == '0) ? emu_mode : mode_q;
   assign start    = accept && (!emu_eff || in_last || slot == SW'(GROUP_WORDS - 1));
   assign nbits    = mode_q ? BCW'(GROUP_W) : BCW'(WORD_W);
   assign done     = fall && (bit_cnt == nbits - 1'b1);

   spi9_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == ST_SHIFT),
      .sck  (spi_sck),
      .fall (fall)
   );

   spi9_group_buf #(.WORD_W(WORD_W), .GROUP_WORDS(GROUP_WORDS)) u_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept),
      .first(slot == '0),
      .slot (slot),
      .word ({in_dc, in_byte}),
      .shift(fall),
      .msb  (msb)
   );

   assign spi_mosi = (state == ST_SHIFT) ? msb : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         slot     <= '0;
         mode_q   <= 1'b0;
         last_q   <= 1'b0;
         bit_cnt  <= '0;
         tail_cnt <= '0;
         spi_cs_n <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               spi_cs_n <= 1'b0;
               mode_q   <= emu_eff;
               if (start) begin
                  state   <= ST_SHIFT;
                  slot    <= '0;
                  bit_cnt <= '0;
                  last_q  <= in_last;
               end else begin
                  slot <= slot + 1'b1;
               end
            end
            ST_SHIFT: if (fall) begin
               bit_cnt <= bit_cnt + 1'b1;
               if (done) begin
                  state    <= last_q ? ST_TAIL : ST_IDLE;
                  tail_cnt <= '0;
               end
            end
            ST_TAIL: begin
               tail_cnt <= tail_cnt + 1'b1;
               if (tail_cnt == TW'(2 * HALF_DIV - 1)) begin
                  spi_cs_n <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R6: no clock pulses while chip-select is inactive
   p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   // R6: data holds across the high phase of the clock
   p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

   // R9: no byte is taken while the clock is running
   p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> !in_ready);

   // R8: chip-select rises only with the clock low and input open again
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> (in_ready && !spi_sck));

   // R8: chip-select is held low for every shifted bit
   p_cs_in_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |-> !spi_cs_n);
endmodule

// File: tb/spi9_display_tx_tb.sv
module spi9_display_tx_tb;
   localparam int H = 2;
   localparam int P = 2 * H;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, emu_mode, in_valid, in_dc, in_last;
   logic [7:0] in_byte;
   logic       in_ready, spi_sck, spi_mosi, spi_cs_n;

   spi9_display_tx #(.BYTE_W(8), .GROUP_WORDS(8), .HALF_DIV(H)) u_dut (
      .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .in_valid(in_valid),
      .in_ready(in_ready), .in_dc(in_dc), .in_byte(in_byte), .in_last(in_last),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
   );

   int errors = 0;
   int checks = 0;

   // behavioural model
   bit m_ready = 1, m_cs_n = 1, m_shift = 0, m_emu = 0, m_lastgrp = 0, m_acc = 0;
   int m_t = 0, m_nb = 0, m_tail = 0;
   bit m_q[$];
   bit [8:0] m_col[$];

   bit rx[$];
   bit exp_bits[$];
   bit prev_sck = 0, prev_mosi = 0;

   function automatic void model_edge();
      m_acc = 0;
      if (m_shift) begin
         m_t++;
         if (m_t == m_nb * P) begin
            m_shift = 0;
            if (m_lastgrp) m_tail = P;
            else m_ready = 1;
         end
      end else if (m_tail > 0) begin
         m_tail--;
         if (m_tail == 0) begin
            m_cs_n  = 1;
            m_ready = 1;
         end
      end else if (in_valid && m_ready) begin
         m_acc = 1;
         if (m_col.size() == 0) m_emu = emu_mode;
         m_col.push_back({in_dc, in_byte});
         m_cs_n = 0;
         if (!m_emu || m_col.size() == 8 || in_last) begin
            m_q.delete();
            foreach (m_col[i]) for (int b = 8; b >= 0; b--) m_q.push_back(m_col[i][b]);
            if (m_emu) while (m_q.size() < 72) m_q.push_back(1'b0);
            m_nb      = m_q.size();
            m_t       = 0;
            m_shift   = 1;
            m_ready   = 0;
            m_lastgrp = in_last;
            m_col.delete();
         end
      end
   endfunction

   task automatic check1(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit e_sck, e_mosi;
      e_sck  = m_shift && ((m_t % P) >= H);
      e_mosi = m_shift ? m_q[m_t / P] : 1'b0;
      check1("R9", "in_ready", in_ready, m_ready);
      check1("R8", "spi_cs_n", spi_cs_n, m_cs_n);
      check1("R7", "spi_sck", spi_sck, e_sck);
      check1("R2", "spi_mosi", spi_mosi, e_mosi);
      if (spi_sck && prev_sck) check1("R6", "mosi held high phase", spi_mosi, prev_mosi);
      if (spi_cs_n) check1("R6", "sck low while deselected", spi_sck, 0);
      if (spi_sck && !prev_sck) rx.push_back(spi_mosi);
      prev_sck  = spi_sck;
      prev_mosi = spi_mosi;
   endtask

   task automatic cyc();
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic send_word(bit dc, bit [7:0] b, bit last);
      in_valid = 1; in_dc = dc; in_byte = b; in_last = last;
      m_acc = 0;
      while (!m_acc) cyc();
      in_valid = 0; in_last = 0;
   endtask

   task automatic wait_idle();
      while (!(m_cs_n && m_ready && !m_shift && m_tail == 0)) cyc();
      cyc();
      cyc();
   endtask

   task automatic burst(string req, bit emu, int n, int gap, bit [7:0] base, bit flip);
      int mism;
      bit [8:0] w;
      rx.delete();
      exp_bits.delete();
      emu_mode = emu;
      for (int i = 0; i < n; i++) begin
         w = {1'(i % 3 != 0), 8'(base + i * 53)};
         for (int b = 8; b >= 0; b--) exp_bits.push_back(w[b]);
         if (emu && (i % 8 == 7 || i == n - 1))
            while (exp_bits.size() % 72 != 0) exp_bits.push_back(1'b0);
      end
      for (int i = 0; i < n; i++) begin
         send_word(1'(i % 3 != 0), 8'(base + i * 53), i == n - 1);
         if (flip && i == 0) emu_mode = !emu;
         for (int g = 0; g < gap; g++) cyc();
      end
      wait_idle();
      check1(req, "captured bit count", rx.size(), exp_bits.size());
      mism = 0;
      foreach (exp_bits[i]) if (i < rx.size() && rx[i] != exp_bits[i]) mism++;
      check1(req, "captured bit mismatches", mism, 0);
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 0; emu_mode = 0; in_valid = 0; in_dc = 0; in_last = 0; in_byte = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check1("R1", "cs_n in reset", spi_cs_n, 1);
      check1("R1", "sck in reset", spi_sck, 0);
      check1("R1", "mosi in reset", spi_mosi, 0);
      check1("R1", "ready in reset", in_ready, 1);
      rst_n = 1;
      cyc();
      check1("R1", "cs_n after reset", spi_cs_n, 1);

      // R2: single command word, flag bit first must be 0
      burst("R2", 0, 1, 0, 8'hA5, 0);
      check1("R2", "command flag bit", rx.size() > 0 ? int'(rx[0]) : -1, 0);
      // R3: native burst with gaps between words
      burst("R3", 0, 4, 3, 8'h3C, 0);
      // R4: one full packed group
      burst("R4", 1, 8, 0, 8'h11, 0);
      // R5: short packed group padded with no-op words
      burst("R5", 1, 3, 1, 8'hC2, 0);
      // R4/R5: full group then a padded one
      burst("R5", 1, 10, 0, 8'h7E, 0);
      // R10: mode change inside a packed group is ignored
      burst("R10", 1, 3, 2, 8'h90, 1);
      // native again after packed traffic
      burst("R3", 0, 2, 0, 8'hF0, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule